// File: doc/BRIEF.md
# Fault-Blanked Low-Side Output Latch

This block holds the on/off control state for a bank of low-side output stages. A single-cycle load strobe comes from the serial front end when chip enable rises. On that strobe the block captures a control word and drives the per-channel gate enables from it on the next clock. Each word bit uses inverted polarity: a 0 turns its channel ON and a 1 turns it OFF.

Every load also starts a blanking window. The window is a fixed number of system clock cycles, set so it covers the inrush interval. While the window runs, the pin-sense fault flags are ignored, so a load switching on can draw a large starting current without tripping.

Once the window ends, the block watches the flags without a break until the next load. Any channel that is ON while its flag reports a high pin is forced OFF. It stays OFF until it is reloaded or the block is reset. Each channel is cleared on its own and never affects the others. The active-low asynchronous reset turns every channel OFF and ends any blanking.

Top module: `outlatch_blank`

## Requirements
- R1: While rst_ni is low and after it is released with no load, gate_o is all zeros and blank_o is 0.
- R2: A clock edge with load_i high captures word_i, and from the next cycle gate_o equals the bitwise inverse of word_i (word bit 0 = channel ON, gate bit 1 = gate driven).
- R3: After the edge that takes a load, blank_o is 1 for exactly BLANK_CYCLES consecutive cycles and then 0.
- R4: While blank_o is 1, fault_i has no effect on gate_o.
- R5: When blank_o is 0 and no load is taken, any channel with gate_o bit 1 and fault_i bit 1 at a clock edge has gate_o bit 0 after that edge.
- R6: A fault clears only its own channel. The other channels keep their state, and a fault on a channel that is already OFF changes nothing.
- R7: A load taken during blanking restarts the full BLANK_CYCLES window from that load, and a load re-enables channels that were cleared by a fault.
- R8: Without a load, no gate_o bit goes from 0 to 1. A cleared channel stays OFF after its fault flag drops.
- R9: Driving rst_ni low clears gate_o and blank_o at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe marking a chip-enable rise |
| word_i | input | N_CH | Control word, bit 0 = ON, bit 1 = OFF |
| fault_i | input | N_CH | Per-channel pin-high sense flags |
| gate_o | output | N_CH | Per-channel gate enables, 1 = channel ON |
| blank_o | output | 1 | High while the blanking window runs |

## Verification
The assertions assume that load_i is a clean single-cycle strobe, already synchronous to clk_i. They also assume that fault_i and word_i are stable around the rising edge. The bench drives every input on the falling edge, so each value is settled well before the edge samples it. The bench pulses load_i for exactly one cycle, with one exception: back-to-back loads, which exercise the restart rule. Fault flags are raised only after the outputs that they should or should not clear have been confirmed.

// File: rtl/outlatch_pkg.sv
package outlatch_pkg;
  localparam int unsigned CH_DEFAULT    = 8;
  localparam int unsigned BLANK_DEFAULT = 16;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BLANK = 2'd1,
    PH_WATCH = 2'd2
  } phase_e;
endpackage

// File: rtl/outlatch_timer.sv
module outlatch_timer
  import outlatch_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = BLANK_DEFAULT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic blank_o,
  output logic watch_o
);
  localparam int unsigned CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(BLANK_CYCLES);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  phase_e        phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= PH_IDLE;
    end else if (start_i) begin
      cnt_q   <= LOAD_VAL;
      phase_q <= PH_BLANK;
    end else if (phase_q == PH_BLANK) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) phase_q <= PH_WATCH;
    end
  end

  assign blank_o = (phase_q == PH_BLANK);
  assign watch_o = (phase_q == PH_WATCH);
endmodule

// File: rtl/outlatch_cell.sv
module outlatch_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic off_bit_i,
  input  logic watch_i,
  input  logic fault_i,
  output logic on_o
);
  logic on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 on_q <= 1'b0;
    else if (load_i)             on_q <= ~off_bit_i;
    else if (watch_i && fault_i) on_q <= 1'b0;  // latched off until next load
  end

  assign on_o = on_q;
endmodule

// File: rtl/outlatch_blank.sv
module outlatch_blank
  import outlatch_pkg::*;
#(
  parameter int unsigned N_CH         = CH_DEFAULT,
  parameter int unsigned BLANK_CYCLES = BLANK_DEFAULT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [N_CH-1:0] word_i,
  input  logic [N_CH-1:0] fault_i,
  output logic [N_CH-1:0] gate_o,
  output logic            blank_o
);
  logic watch;

  outlatch_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(load_i),
    .blank_o(blank_o),
    .watch_o(watch)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    outlatch_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .off_bit_i(word_i[c]),
      .watch_i  (watch),
      .fault_i  (fault_i[c]),
      .on_o     (gate_o[c])
    );
  end
endmodule

// File: rtl/outlatch_blank_chk.sv
module outlatch_blank_chk #(
  parameter int unsigned N_CH         = 8,
  parameter int unsigned BLANK_CYCLES = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            load_i,
  input logic [N_CH-1:0] word_i,
  input logic [N_CH-1:0] fault_i,
  input logic [N_CH-1:0] gate_o,
  input logic            blank_o
);
  localparam int unsigned CW = $clog2(BLANK_CYCLES + 2);
  logic [CW-1:0] blank_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   blank_run_q <= '0;
    else if (load_i)                               blank_run_q <= '0;
    else if (blank_o && blank_run_q != {CW{1'b1}}) blank_run_q <= blank_run_q + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (gate_o == '0 && !blank_o); // R9
    end
  end

  AST_LOAD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> gate_o == ~$past(word_i)); // R2

  AST_BLANK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> blank_o); // R3

  AST_BLANK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(blank_run_q) <= BLANK_CYCLES); // R3

  AST_HOLD_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_o && !load_i) |=> gate_o == $past(gate_o)); // R4

  AST_FAULT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_o && !load_i) |=> (gate_o & $past(fault_i)) == '0); // R5

  AST_NO_SPURIOUS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (gate_o & ~$past(gate_o)) == '0); // R8

  AST_ONLY_FAULTED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($past(gate_o) & ~gate_o & ~$past(fault_i)) == '0); // R6
endmodule

bind outlatch_blank outlatch_blank_chk #(.N_CH(N_CH), .BLANK_CYCLES(BLANK_CYCLES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .word_i (word_i),
  .fault_i(fault_i),
  .gate_o (gate_o),
  .blank_o(blank_o)
);

// File: tb/tb_outlatch_blank.sv
module tb_outlatch_blank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int BLANK = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           load = 1'b0;
  logic [NCH-1:0] word = '0;
  logic [NCH-1:0] fault = '0;
  logic [NCH-1:0] gate;
  logic           blank;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  outlatch_blank #(.N_CH(NCH), .BLANK_CYCLES(BLANK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .word_i(word),
    .fault_i(fault), .gate_o(gate), .blank_o(blank)
  );

  task automatic check(input string req, input logic [NCH:0] act, input logic [NCH:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // strobe load for one edge; returns at the negedge after it
  task automatic do_load(input logic [NCH-1:0] w);
    word = w;
    load = 1'b1;
    step(1);
    load = 1'b0;
  endtask

  task automatic wait_watch();
    while (blank) step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(2);
    check("R1 in reset", {blank, gate}, '0);
    rst_n = 1'b1;
    step(3);
    check("R1 after release", {blank, gate}, '0);

    // R2: every control word, back-to-back loads
    for (int w = 0; w < 256; w++) begin
      do_load(NCH'(w));
      check("R2 load word", {1'b0, gate}, {1'b0, ~NCH'(w)});
    end

    // R3: window length
    do_load(8'h00);
    for (int j = 0; j < BLANK; j++) begin
      check("R3 blank high", {NCH'(0), blank}, {NCH'(0), 1'b1});
      step(1);
    end
    check("R3 blank low", {NCH'(0), blank}, '0);

    // R4/R5/R6/R8
    do_load(8'h00);
    fault = 8'hA5;
    for (int j = 0; j < BLANK; j++) begin
      check("R4 fault ignored", {blank, gate}, {1'b1, 8'hFF});
      step(1);
    end
    check("R4 last edge of window", {blank, gate}, {1'b0, 8'hFF});
    step(1);
    check("R5 R6 fault clears own bits", {blank, gate}, {1'b0, 8'h5A});
    fault = 8'h00;
    step(4);
    check("R8 stays off", {blank, gate}, {1'b0, 8'h5A});

    // R7: reload re-enables, restart inside window
    do_load(8'h00);
    check("R7 reload enables", {blank, gate}, {1'b1, 8'hFF});
    step(3);
    do_load(8'h0F);
    for (int j = 0; j < BLANK; j++) begin
      check("R7 restarted window", {NCH'(0), blank}, {NCH'(0), 1'b1});
      step(1);
    end
    check("R7 window end", {blank, gate}, {1'b0, 8'hF0});

    // R6: off channels ignore faults, per-channel sweep
    fault = 8'h0F;
    step(3);
    check("R6 fault on off channels", {blank, gate}, {1'b0, 8'hF0});
    fault = 8'h00;
    for (int c = 0; c < NCH; c++) begin
      do_load(8'h00);
      wait_watch();
      fault = NCH'(1) << c;
      step(1);
      fault = '0;
      step(1);
      check("R6 single channel", {1'b0, gate}, {1'b0, ~(NCH'(1) << c)});
    end

    // R9: asynchronous reset mid-window
    do_load(8'h00);
    step(1);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R9 async clear", {blank, gate}, '0);
    step(2);
    rst_n = 1'b1;
    step(2);
    check("R1 post reset idle", {blank, gate}, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule